// File: doc/BRIEF.md
# Multichannel DMA Bus-Master Sequencer

This block sits between a set of DMA channels and a shared system bus. Each channel holds a request line high together with a static description of one transfer: direction, transfer kind, start address, byte order and a character-traffic flag. The sequencer selects the lowest-numbered pending channel and asks an external arbiter for the bus. Once granted, it runs exactly one logical transfer for that channel and then gives the bus back.

The memory port width is given on an input. When that width is narrower than the element being moved, the element is split into back-to-back bus transactions. The bus is held until the last of these transactions is acknowledged. Write data is taken one element at a time from the channel. Read data is assembled and returned one element at a time. Both can be byte-reversed per channel. If the grant is still parked on this master when a channel becomes pending, the first transaction starts without a separate request cycle.

Top module: `dma_bus_sequencer`

## Requirements
- R1: When several channels have their request high in the same idle cycle, the lowest channel index is served first. The others wait for later transfers.
- R2: If `bus_gnt` is low when a channel is picked, `bus_req` is raised and the first transaction appears in the cycle after `bus_gnt` is sampled high. If `bus_gnt` is already high in the idle cycle, the first transaction appears in the cycle after the request is sampled.
- R3: On the acknowledge of the final transaction, `bus_req` and `m_valid` fall together and `done` pulses for that channel for one cycle. `bus_req` then stays low for at least one more cycle. After reset, `bus_req`, `m_valid` and `done` are low.
- R4: `ch_kind` is encoded as follows. 0 is a byte, 1 a 16-bit half-word, 2 a 32-bit word, 3 a 64-bit doubleword. 4, 5 and 6 are bursts of 2, 3 and 4 doubleword elements. 7 acts as 3. `m_blen` carries the element count minus one.
- R5: `port_w` values 0..3 mean 8, 16, 32 and 64 bits. Each transaction moves the smaller of the element size and the port width, and `m_size` gives the log2 of its byte count. Addresses ascend by that byte count from the start address. The next transaction is presented in the cycle right after an acknowledge, so `m_valid` does not drop inside a transfer.
- R6: Write data on `m_wdata` is right-justified: bits 7:0 hold the lowest-address byte of the transaction, and lanes above its size are zero.
- R7: For each transaction, only the low lanes of `m_rdata` that match its size are used. For each element, one `rd_valid` pulse for that channel appears in the cycle after its last acknowledge. `rd_data` then holds the element with the lowest-address byte in bits 7:0 and zeros above the element size.
- R8: With `ch_be` set, the byte order inside each element is reversed, for both reads and writes.
- R9: A channel with `ch_char` set always reads a single 16-bit half-word, whatever its `ch_kind`.
- R10: A channel with `ch_char` set always writes a single byte, whatever its `ch_kind`, so each character reaches memory on its own.
- R11: `wr_pull` pulses for one cycle each time the channel's current `ch_wdata` word has been captured for a write element. The following element uses the word presented after that pulse.
- R12: While `m_valid` is high and `m_ack` is low, `m_valid`, `m_addr`, `m_size` and `m_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_req | input | NCH | Per-channel transfer request, held until done |
| ch_we | input | NCH | Per-channel direction, 1 = write to memory |
| ch_kind | input | 3*NCH | Per-channel transfer kind (R4) |
| ch_be | input | NCH | Per-channel big-endian byte order |
| ch_char | input | NCH | Per-channel character-traffic mode |
| ch_addr | input | AW*NCH | Per-channel start byte address |
| ch_wdata | input | 64*NCH | Per-channel current write element |
| bus_gnt | input | 1 | Grant from the external arbiter |
| port_w | input | 2 | Memory port width code (R5) |
| m_ack | input | 1 | Transaction acknowledge |
| m_rdata | input | 64 | Read data, right-justified |
| bus_req | output | 1 | Bus request to the arbiter |
| m_valid | output | 1 | Transaction valid |
| m_we | output | 1 | Transaction is a write |
| m_addr | output | AW | Transaction byte address |
| m_size | output | 2 | log2 of transaction byte count |
| m_blen | output | 2 | Elements in the logical transfer minus one |
| m_wdata | output | 64 | Write data, right-justified |
| wr_pull | output | NCH | Write word captured for a channel |
| rd_valid | output | NCH | Read element ready for a channel |
| rd_data | output | 64 | Assembled read element |
| done | output | NCH | Transfer finished for a channel |

## Verification
Every result is registered. The first transaction is visible one cycle after the edge that sampled the grant, or the request when the grant is parked. Each later transaction follows one cycle after the edge that sampled the previous acknowledge. `rd_valid`, `done` and the fall of `bus_req` all land one cycle after the final acknowledge edge. The bench drives every input and samples every output on the falling clock edge. It models the arbiter and memory with grant and acknowledge delays of zero to two cycles, and it pops each predicted transaction, element and completion from its queues in the cycle that follows those edges.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  localparam int DW = 64;

  localparam logic [2:0] K_BYTE   = 3'd0;
  localparam logic [2:0] K_HALF   = 3'd1;
  localparam logic [2:0] K_WORD   = 3'd2;
  localparam logic [2:0] K_DWORD  = 3'd3;
  localparam logic [2:0] K_BURST2 = 3'd4;
  localparam logic [2:0] K_BURST3 = 3'd5;
  localparam logic [2:0] K_BURST4 = 3'd6;

  typedef enum logic [1:0] {S_IDLE, S_ARB, S_XFER, S_REL} seq_state_e;

  // low (1 << s) bytes set
  function automatic logic [DW-1:0] lane_mask(input logic [1:0] s);
    lane_mask = (s == 2'd3) ? '1 : ((64'd1 << (7'd8 << s)) - 64'd1);
  endfunction

  // keep the low element bytes, reversed when be is set
  function automatic logic [DW-1:0] lane_swap(input logic [DW-1:0] x,
                                              input logic [1:0] esz,
                                              input logic be);
    logic [DW-1:0] y;
    int n;
    n = 1 << esz;
    y = '0;
    for (int i = 0; i < 8; i++) begin
      if (i < n) y[8*i +: 8] = be ? x[8*(n-1-i) +: 8] : x[8*i +: 8];
    end
    return y;
  endfunction
endpackage

// File: rtl/dbs_prio.sv
module dbs_prio #(
  parameter int N  = 4,
  localparam int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [CW-1:0] idx
);
  logic [N-1:0] win;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_win
      if (g == 0) begin : g_first
        assign win[g] = req[g];
      end else begin : g_rest
        assign win[g] = req[g] & ~(|req[g-1:0]);
      end
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (win[i]) idx = idx | CW'(i);
    end
  end

  assign any = |req;
endmodule

// File: rtl/dbs_plan.sv
module dbs_plan
  import dbs_pkg::*;
(
  input  logic [2:0] kind,
  input  logic       we,
  input  logic       chr,
  input  logic [1:0] pw,
  output logic [1:0] esz,
  output logic [1:0] ssz,
  output logic [1:0] nlog_m1,
  output logic [2:0] nsub_m1
);
  always_comb begin
    esz     = 2'd3;
    nlog_m1 = 2'd0;
    if (chr) begin
      esz = we ? 2'd0 : 2'd1;
    end else begin
      case (kind)
        K_BYTE:   esz = 2'd0;
        K_HALF:   esz = 2'd1;
        K_WORD:   esz = 2'd2;
        K_BURST2: nlog_m1 = 2'd1;
        K_BURST3: nlog_m1 = 2'd2;
        K_BURST4: nlog_m1 = 2'd3;
        default:  ;
      endcase
    end
    ssz     = (pw < esz) ? pw : esz;
    nsub_m1 = 3'((4'd1 << (esz - ssz)) - 4'd1);
  end
endmodule

// File: rtl/dma_bus_sequencer.sv
module dma_bus_sequencer
  import dbs_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    ch_req,
  input  logic [NCH-1:0]    ch_we,
  input  logic [3*NCH-1:0]  ch_kind,
  input  logic [NCH-1:0]    ch_be,
  input  logic [NCH-1:0]    ch_char,
  input  logic [AW*NCH-1:0] ch_addr,
  input  logic [DW*NCH-1:0] ch_wdata,
  input  logic              bus_gnt,
  input  logic [1:0]        port_w,
  input  logic              m_ack,
  input  logic [DW-1:0]     m_rdata,
  output logic              bus_req,
  output logic              m_valid,
  output logic              m_we,
  output logic [AW-1:0]     m_addr,
  output logic [1:0]        m_size,
  output logic [1:0]        m_blen,
  output logic [DW-1:0]     m_wdata,
  output logic [NCH-1:0]    wr_pull,
  output logic [NCH-1:0]    rd_valid,
  output logic [DW-1:0]     rd_data,
  output logic [NCH-1:0]    done
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

  seq_state_e    st;
  logic [CW-1:0] cur, pick_idx, src;
  logic          pick_any;
  logic [1:0]    esz_q, ssz_q, nlog_m1_q;
  logic [2:0]    nsub_m1_q, scnt, s_next;
  logic [1:0]    lcnt;
  logic          we_q, be_q;
  logic [DW-1:0] wbuf, acc;

  dbs_prio #(.N(NCH)) u_prio (.req(ch_req), .any(pick_any), .idx(pick_idx));

  assign src = (st == S_IDLE) ? pick_idx : cur;

  logic [1:0] p_esz, p_ssz, p_nlog_m1;
  logic [2:0] p_nsub_m1;
  dbs_plan u_plan (
    .kind(ch_kind[src*3 +: 3]), .we(ch_we[src]), .chr(ch_char[src]), .pw(port_w),
    .esz(p_esz), .ssz(p_ssz), .nlog_m1(p_nlog_m1), .nsub_m1(p_nsub_m1)
  );

  logic launch, ack, last_sub, last_log, fin, cap_new;
  assign launch   = ((st == S_IDLE) && pick_any && bus_gnt) || ((st == S_ARB) && bus_gnt);
  assign ack      = (st == S_XFER) && m_valid && m_ack;
  assign last_sub = (scnt == nsub_m1_q);
  assign last_log = (lcnt == nlog_m1_q);
  assign fin      = ack && last_sub && last_log;
  assign cap_new  = launch || (ack && last_sub && !last_log);

  // next write piece
  logic [1:0]    esz_use, ssz_use;
  logic          be_use;
  logic [DW-1:0] wsrc, wd_next;
  logic [5:0]    boff_n, boff_c;
  logic [DW-1:0] piece, asm_full;
  logic [NCH-1:0] cur_oh, src_oh;

  assign esz_use = launch ? p_esz : esz_q;
  assign ssz_use = launch ? p_ssz : ssz_q;
  assign be_use  = launch ? ch_be[src] : be_q;
  assign wsrc    = cap_new ? lane_swap(ch_wdata[src*DW +: DW], esz_use, be_use) : wbuf;
  assign s_next  = (launch || last_sub) ? 3'd0 : scnt + 3'd1;
  assign boff_n  = 6'(s_next) << ssz_use;
  assign wd_next = (wsrc >> {boff_n, 3'b000}) & lane_mask(ssz_use);

  // read assembly
  assign boff_c   = 6'(scnt) << ssz_q;
  assign piece    = (m_rdata & lane_mask(ssz_q)) << {boff_c, 3'b000};
  assign asm_full = acc | piece;
  assign cur_oh   = NCH'(1) << cur;
  assign src_oh   = NCH'(1) << src;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; cur <= '0; bus_req <= 1'b0; m_valid <= 1'b0; m_we <= 1'b0;
      m_addr <= '0; m_size <= '0; m_blen <= '0; m_wdata <= '0;
      wr_pull <= '0; rd_valid <= '0; rd_data <= '0; done <= '0;
      esz_q <= '0; ssz_q <= '0; nlog_m1_q <= '0; nsub_m1_q <= '0;
      scnt <= '0; lcnt <= '0; we_q <= 1'b0; be_q <= 1'b0; wbuf <= '0; acc <= '0;
    end else begin
      wr_pull  <= '0;
      rd_valid <= '0;
      done     <= '0;
      if (launch) begin
        st <= S_XFER; bus_req <= 1'b1; m_valid <= 1'b1;
        esz_q <= p_esz; ssz_q <= p_ssz; nlog_m1_q <= p_nlog_m1; nsub_m1_q <= p_nsub_m1;
        we_q <= ch_we[src]; be_q <= ch_be[src]; m_we <= ch_we[src];
        m_addr <= ch_addr[src*AW +: AW]; m_size <= p_ssz; m_blen <= p_nlog_m1;
        m_wdata <= wd_next; wbuf <= wsrc; scnt <= '0; lcnt <= '0; acc <= '0;
        if (ch_we[src]) wr_pull <= src_oh;
      end
      case (st)
        S_IDLE: if (pick_any) begin
          cur <= pick_idx;
          if (!bus_gnt) begin st <= S_ARB; bus_req <= 1'b1; end
        end
        S_ARB: ;
        S_XFER: if (ack) begin
          if (!we_q) begin
            if (last_sub) begin
              rd_data  <= lane_swap(asm_full, esz_q, be_q);
              rd_valid <= cur_oh;
              acc      <= '0;
            end else begin
              acc <= asm_full;
            end
          end
          if (fin) begin
            st <= S_REL; bus_req <= 1'b0; m_valid <= 1'b0; done <= cur_oh;
          end else begin
            m_addr  <= m_addr + (AW'(1) << ssz_q);
            m_wdata <= wd_next;
            scnt    <= s_next;
            if (last_sub) begin
              lcnt <= lcnt + 2'd1;
              wbuf <= wsrc;
              if (we_q) wr_pull <= cur_oh;
            end
          end
        end
        S_REL: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3
  done_release_chk: assert property (@(posedge clk) disable iff (rst)
    (|done) |-> (!bus_req && !m_valid));
  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(done));
  // R2
  own_bus_chk: assert property (@(posedge clk) disable iff (rst) m_valid |-> bus_req);
  // R2
  start_on_gnt_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(m_valid) |-> $past(bus_gnt));
  // R5
  back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_ack) |=> (m_valid || (|done)));
  // R12
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ack) |=> (m_valid && $stable(m_addr) && $stable(m_size) && $stable(m_wdata)));
  // R7
  rd_single_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(rd_valid));
endmodule

// File: tb/dma_bus_sequencer_tb_top.sv
module dma_bus_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int AW  = 32;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst;
  logic [NCH-1:0] ch_req, ch_we, ch_be, ch_char;
  logic [3*NCH-1:0] ch_kind;
  logic [AW*NCH-1:0] ch_addr;
  logic [64*NCH-1:0] ch_wdata;
  logic bus_gnt, m_ack;
  logic [1:0] port_w;
  logic [63:0] m_rdata;
  logic bus_req, m_valid, m_we;
  logic [AW-1:0] m_addr;
  logic [1:0] m_size, m_blen;
  logic [63:0] m_wdata, rd_data;
  logic [NCH-1:0] wr_pull, rd_valid, done;

  dma_bus_sequencer #(.NCH(NCH), .AW(AW)) dut_i (
    .clk(clk), .rst(rst), .ch_req(ch_req), .ch_we(ch_we), .ch_kind(ch_kind),
    .ch_be(ch_be), .ch_char(ch_char), .ch_addr(ch_addr), .ch_wdata(ch_wdata),
    .bus_gnt(bus_gnt), .port_w(port_w), .m_ack(m_ack), .m_rdata(m_rdata),
    .bus_req(bus_req), .m_valid(m_valid), .m_we(m_we), .m_addr(m_addr),
    .m_size(m_size), .m_blen(m_blen), .m_wdata(m_wdata), .wr_pull(wr_pull),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done)
  );

  typedef struct { logic [31:0] addr; logic we; logic [1:0] sz; logic [1:0] bl; logic [63:0] wd; } tx_t;
  typedef struct { int ch; logic [63:0] d; } rd_t;
  tx_t txq[$];
  rd_t rdq[$];
  int  doneq[$];

  int checks = 0, errors = 0;
  int widx[NCH], pred[NCH], pulls[NCH];
  int done_log[$];
  bit park = 0, seen = 0, rel_chk = 0, prev_gnt = 0, prev_valid = 0;
  int wait_n = 0, ntx = 0, gcnt = 0;
  logic [31:0] hold_addr;
  logic [63:0] hold_wd;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] wfn(input int c, input int k);
    return {8'(c), 8'(k), 8'h3C, 8'hC3, 8'(k*7+1), 8'(c*5+2), 8'h96, 8'h69};
  endfunction

  function automatic logic [7:0] mb(input logic [31:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  task automatic setup(input int c, input bit we, input logic [2:0] k, input bit be,
                       input bit chr, input logic [31:0] base);
    int esz, nlog, n, ps, p;
    tx_t t;
    rd_t r;
    logic [63:0] w, v;
    ch_we[c] = we; ch_be[c] = be; ch_char[c] = chr;
    ch_kind[c*3 +: 3] = k; ch_addr[c*AW +: AW] = base;
    if (chr) begin esz = we ? 0 : 1; nlog = 1; end
    else case (k)
      0: begin esz = 0; nlog = 1; end
      1: begin esz = 1; nlog = 1; end
      2: begin esz = 2; nlog = 1; end
      4: begin esz = 3; nlog = 2; end
      5: begin esz = 3; nlog = 3; end
      6: begin esz = 3; nlog = 4; end
      default: begin esz = 3; nlog = 1; end
    endcase
    n  = 1 << esz;
    ps = (int'(port_w) < esz) ? int'(port_w) : esz;
    p  = 1 << ps;
    for (int l = 0; l < nlog; l++) begin
      w = wfn(c, pred[c] + l);
      v = '0;
      for (int j = 0; j < n / p; j++) begin
        t.addr = base + 32'(l*n + j*p); t.we = we; t.sz = 2'(ps); t.bl = 2'(nlog-1); t.wd = '0;
        for (int b = 0; b < p; b++) begin
          int i;
          i = j*p + b;
          t.wd[8*b +: 8] = be ? w[8*(n-1-i) +: 8] : w[8*i +: 8];
        end
        txq.push_back(t);
      end
      for (int i = 0; i < n; i++) begin
        if (be) v[8*(n-1-i) +: 8] = mb(base + 32'(l*n + i));
        else    v[8*i +: 8]       = mb(base + 32'(l*n + i));
      end
      if (!we) begin r.ch = c; r.d = v; rdq.push_back(r); end
    end
    if (we) pred[c] += nlog;
    doneq.push_back(c);
  endtask

  task automatic go(input logic [NCH-1:0] mask);
    ch_req = ch_req | mask;
    @(negedge clk);
    while ((ch_req & mask) != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // scoreboard monitor, memory and arbiter model
  always @(negedge clk) begin
    if (rst) begin
      m_ack = 0; seen = 0; bus_gnt = 0; gcnt = 0; prev_gnt = 0; prev_valid = 0;
    end else begin
      if (m_ack) begin seen = 0; m_ack = 0; end
      if (m_valid && !prev_valid) chk(prev_gnt, "R2 start after grant", 64'(prev_gnt), 1);
      if (m_valid && !seen) begin
        tx_t e;
        if (txq.size() == 0) chk(0, "R5 unexpected transaction", 64'(m_addr), 0);
        else begin
          e = txq.pop_front();
          chk(m_addr == e.addr && m_size == e.sz && m_we == e.we && m_blen == e.bl,
              "R4 R5 transaction shape", {m_addr, 26'd0, m_blen, m_size, m_we, 1'b0},
              {e.addr, 26'd0, e.bl, e.sz, e.we, 1'b0});
          if (e.we) chk(m_wdata == e.wd, "R6 R8 write lanes", m_wdata, e.wd);
        end
        seen = 1; wait_n = ntx % 3; ntx++;
        hold_addr = m_addr; hold_wd = m_wdata;
      end else if (m_valid && seen) begin
        chk(m_addr == hold_addr && m_wdata == hold_wd, "R12 hold while waiting", m_addr, hold_addr);
      end
      if (m_valid && seen) begin
        if (wait_n == 0) begin
          m_ack = 1;
          for (int b = 0; b < 8; b++)
            m_rdata[8*b +: 8] = (b < (1 << m_size)) ? mb(m_addr + 32'(b)) : 8'hEE;
        end else wait_n--;
      end
      if (rel_chk) begin chk(!bus_req, "R3 release gap", 64'(bus_req), 0); rel_chk = 0; end
      for (int c = 0; c < NCH; c++) begin
        if (rd_valid[c]) begin
          rd_t r;
          if (rdq.size() == 0) chk(0, "R7 unexpected element", rd_data, 0);
          else begin
            r = rdq.pop_front();
            chk(r.ch == c && rd_data == r.d, "R7 R8 read element", rd_data, r.d);
          end
        end
        if (wr_pull[c]) begin
          widx[c]++; pulls[c]++;
          ch_wdata[c*64 +: 64] = wfn(c, widx[c]);
        end
        if (done[c]) begin
          int e;
          e = (doneq.size() == 0) ? -1 : doneq.pop_front();
          chk(e == c, "R1 R3 completion order", 64'(c), 64'(e));
          chk(!bus_req && !m_valid, "R3 release with done", {62'd0, bus_req, m_valid}, 0);
          done_log.push_back(c);
          ch_req[c] = 0; rel_chk = 1;
        end
      end
      if (park) bus_gnt = 1;
      else if (bus_req) begin gcnt++; if (gcnt >= 2) bus_gnt = 1; end
      else begin gcnt = 0; bus_gnt = 0; end
      prev_gnt = bus_gnt; prev_valid = m_valid;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p0;
    rst = 1; ch_req = 0; ch_we = 0; ch_be = 0; ch_char = 0; ch_kind = 0; ch_addr = 0;
    port_w = 3; m_rdata = 0; m_ack = 0; bus_gnt = 0;
    for (int c = 0; c < NCH; c++) begin
      widx[c] = 0; pred[c] = 0; pulls[c] = 0; ch_wdata[c*64 +: 64] = wfn(c, 0);
    end
    repeat (4) @(negedge clk);
    chk(!bus_req && !m_valid && done == 0, "R3 reset state", {bus_req, m_valid, 62'(done)}, 0);
    rst = 0;
    @(negedge clk);

    port_w = 3; setup(0, 1, 3'd2, 0, 0, 32'h1000); go(4'b0001);
    chk(txq.size() == 0 && doneq.size() == 0, "R4 word write drained", 64'(txq.size()), 0);

    port_w = 2; setup(0, 0, 3'd3, 0, 0, 32'h2000); go(4'b0001);
    chk(txq.size() == 0 && rdq.size() == 0, "R5 doubleword over 32-bit port", 64'(rdq.size()), 0);

    port_w = 1; p0 = pulls[1]; setup(1, 1, 3'd6, 0, 0, 32'h3000); go(4'b0010);
    chk(pulls[1] == p0 + 4, "R11 word pulls per burst", 64'(pulls[1] - p0), 4);
    chk(txq.size() == 0, "R6 burst over 16-bit port", 64'(txq.size()), 0);

    port_w = 0; setup(2, 0, 3'd1, 1, 0, 32'h4006); go(4'b0100);
    chk(rdq.size() == 0, "R8 big-endian half over 8-bit port", 64'(rdq.size()), 0);

    port_w = 3; setup(3, 0, 3'd3, 0, 1, 32'h5010); go(4'b1000);
    chk(txq.size() == 0 && rdq.size() == 0, "R9 character read", 64'(txq.size()), 0);
    p0 = pulls[3]; setup(3, 1, 3'd6, 0, 1, 32'h5021); go(4'b1000);
    chk(txq.size() == 0 && pulls[3] == p0 + 1, "R10 character write", 64'(pulls[3] - p0), 1);

    port_w = 2; done_log.delete();
    setup(1, 1, 3'd1, 0, 0, 32'h6000); setup(2, 0, 3'd2, 1, 0, 32'h6100); go(4'b0110);
    chk(done_log.size() == 2 && done_log[0] == 1, "R1 lowest index first",
        64'(done_log.size() > 0 ? done_log[0] : -1), 1);

    park = 1; port_w = 3; setup(0, 1, 3'd0, 0, 0, 32'h7003);
    ch_req[0] = 1; @(negedge clk);
    chk(m_valid == 1, "R2 parked grant start", 64'(m_valid), 1);
    while (ch_req[0]) @(negedge clk);
    repeat (3) @(negedge clk);
    setup(1, 0, 3'd5, 1, 0, 32'h7100); go(4'b0010);
    chk(rdq.size() == 0, "R8 big-endian three-element burst read", 64'(rdq.size()), 0);
    port_w = 2; setup(2, 1, 3'd4, 1, 0, 32'h7200); go(4'b0100);
    chk(txq.size() == 0, "R5 two-element burst over 32-bit port", 64'(txq.size()), 0);
    park = 0;

    port_w = 3; setup(0, 0, 3'd7, 0, 0, 32'h8008); go(4'b0001);
    chk(txq.size() == 0 && rdq.size() == 0 && doneq.size() == 0, "R4 code 7 as doubleword",
        64'(txq.size() + rdq.size() + doneq.size()), 0);

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule